// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Words are written on the write clock and read on the read clock, in order. The write and read positions are exchanged between the two clock domains as Gray-coded values through two-register synchronizers. Flags that concern free space are produced in the write domain. Flags that concern stored data are produced in the read domain.

Two timing modes exist, and the mode is taken from a select input while master reset is held. In standard mode the read-side flag means "empty", the write-side flag means "full", and a read request fetches a word onto the data output. In first-word-fall-through mode the read-side flag means "output ready" and the write-side flag means "input ready". The oldest word then appears on the data output without any request, and a read request consumes it.

Half-full, almost-empty and almost-full flags work in both modes. The two almost thresholds are offsets supplied on input ports by an external register. A partial reset empties the buffer and keeps the latched mode. An active-low retransmit input rewinds the read position so that stored data can be read again.

Top module: `dcf_fifo`

## Requirements
- R1: While `mst_rst` is high, both positions return to location 0 and the mode is latched from `fwft_sel` (0 = standard, 1 = first-word-fall-through). After master reset, standard mode shows `rd_flag`=1 and `wr_flag`=0, and fall-through mode shows `rd_flag`=0 and `wr_flag`=1. In both modes `almost_empty`=1, `half_full`=0 and `almost_full`=0.
- R2: In standard mode, `rd_flag` is 1 exactly when no word is stored and `wr_flag` is 1 exactly when DEPTH words are stored. A `rd_en` sampled on a rising `rd_clk` edge while `rd_flag`=0 places the oldest word on `dout` at that edge. Words leave in the order they were written.
- R3: In fall-through mode, the oldest word is driven on `dout` with `rd_flag`=1 and no request. A `rd_en` on a rising `rd_clk` edge while `rd_flag`=1 consumes that word, and the next word (if any) is shown at the same edge. `rd_flag` returns to 0 when the last word is taken. `dout` does not change while `rd_flag`=1 and no read or retransmit occurs. `wr_flag`=1 means space is free, and the buffer holds DEPTH+1 words (DEPTH in memory plus the presented word).
- R4: A write while the buffer is full (standard `wr_flag`=1, fall-through `wr_flag`=0) is dropped. A standard-mode read while `rd_flag`=1 is dropped and leaves `dout` unchanged.
- R5: `half_full` is 1 when the write-side count exceeds DEPTH/2. The write-side count is the number of words in memory and does not include a word presented in fall-through mode.
- R6: `almost_empty` is 1 when the read-side count is at most `ae_offset`. The read-side count includes a word presented in fall-through mode.
- R7: `almost_full` is 1 when the write-side count is at least DEPTH minus `af_offset`.
- R8: While `prt_rst` is high, both positions return to location 0 and the buffer empties. The latched mode is kept and `fwft_sel` is ignored. The flags then follow the kept mode and the current offsets.
- R9: When `rt_n` is sampled low on a rising `rd_clk` edge, the read position returns to location 0. The words written since the last reset can then be read again. This is valid only if no more than DEPTH words have been written since that reset and the write side is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| mst_rst | input | 1 | Master reset, synchronous, active high; latches the mode |
| prt_rst | input | 1 | Partial reset, synchronous, active high; keeps the mode |
| fwft_sel | input | 1 | Mode select sampled during master reset (1 = fall-through) |
| ae_offset | input | ADDR_W+1 | Almost-empty offset from the empty boundary |
| af_offset | input | ADDR_W+1 | Almost-full offset from the full boundary |
| wr_en | input | 1 | Write request |
| din | input | WIDTH | Write data |
| wr_flag | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | Write-side count above DEPTH/2 |
| almost_full | output | 1 | Write-side count at or above DEPTH - af_offset |
| rd_en | input | 1 | Read request |
| rt_n | input | 1 | Retransmit, active low |
| dout | output | WIDTH | Read data |
| rd_flag | output | 1 | Empty (standard) or output ready (fall-through) |
| almost_empty | output | 1 | Read-side count at or below ae_offset |

## Verification
The buffer is filled one word at a time and drained one word at a time in standard mode, and every flag is checked at each count after the positions have crossed. This exposes off-by-one errors at the half-full threshold and at both offset thresholds. Writes against a full buffer and reads against an empty one show whether dropped requests leave the stored contents and `dout` alone. Long random interleavings of write and read requests, run in both modes, check ordering and the domain crossing under changing occupancy. Directed sequences show the difference between rewinding and resetting by re-reading after a retransmit. They also show that a partial reset keeps the mode, which is visible in the polarity of `rd_flag` and `wr_flag`.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {TM_STD = 1'b0, TM_FWFT = 1'b1} tmode_e;
endpackage

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic             wr_clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_clk,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) store[waddr] <= wdata;
  end

  // registered read port, no reset, so block RAM can be inferred
  always_ff @(posedge rd_clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end
  end

  // Gray to binary: bit i is the XOR of all Gray bits at or above i
  always_comb begin
    for (int i = 0; i < W; i++) bin_out[i] = ^(s2 >> i);
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          mst_rst,
  input  logic          prt_rst,
  input  logic          fwft_sel,
  input  logic          wr_en,
  input  logic [CW-1:0] af_offset,
  input  logic [CW-1:0] rptr_sync,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [CW-1:0] wgray,
  output logic          wr_flag,
  output logic          half_full,
  output logic          almost_full
);
  tmode_e        mode_q;
  logic [CW-1:0] wptr, wptr_nxt, wcnt;
  logic          full;

  always_ff @(posedge clk) begin
    if (mst_rst) mode_q <= fwft_sel ? TM_FWFT : TM_STD;
  end

  assign wcnt     = wptr - rptr_sync;
  assign full     = (wcnt == CW'(DEPTH));
  assign push     = wr_en && !full;
  assign wptr_nxt = wptr + CW'(1);
  assign waddr    = wptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (mst_rst || prt_rst) begin
      wptr  <= '0;
      wgray <= '0;
    end else if (push) begin
      wptr  <= wptr_nxt;
      wgray <= wptr_nxt ^ (wptr_nxt >> 1);
    end
  end

  assign wr_flag     = (mode_q == TM_FWFT) ? !full : full;
  assign half_full   = (wcnt > CW'(DEPTH / 2));
  assign almost_full = (({1'b0, wcnt} + {1'b0, af_offset}) >= (CW + 1)'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (mst_rst || prt_rst)
    wcnt <= CW'(DEPTH)); // R4
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (mst_rst || prt_rst)
    (full && wr_en) |=> $stable(wptr)); // R4
  AST_MODE_KEEP_W: assert property (@(posedge clk) disable iff (mst_rst)
    prt_rst |=> $stable(mode_q)); // R8
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          mst_rst,
  input  logic          prt_rst,
  input  logic          fwft_sel,
  input  logic          rd_en,
  input  logic          rt_n,
  input  logic [CW-1:0] ae_offset,
  input  logic [CW-1:0] wptr_sync,
  output logic          fetch,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] rgray,
  output logic          rd_flag,
  output logic          almost_empty,
  output logic          fwft_mode
);
  tmode_e        mode_q;
  logic [CW-1:0] rptr, rptr_nxt, ram_cnt, rd_cnt;
  logic          ram_has, valid_q;

  always_ff @(posedge clk) begin
    if (mst_rst) mode_q <= fwft_sel ? TM_FWFT : TM_STD;
  end

  assign fwft_mode = (mode_q == TM_FWFT);
  assign ram_cnt   = wptr_sync - rptr;
  assign ram_has   = (ram_cnt != '0);
  assign rptr_nxt  = rptr + CW'(1);
  assign raddr     = rptr[AW-1:0];

  // fall-through refills the output whenever it is free or being consumed
  assign fetch = rt_n && (fwft_mode ? (ram_has && (!valid_q || rd_en))
                                    : (rd_en && ram_has));

  always_ff @(posedge clk) begin
    if (mst_rst || prt_rst || !rt_n) begin
      rptr    <= '0;
      rgray   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (fetch) begin
        rptr  <= rptr_nxt;
        rgray <= rptr_nxt ^ (rptr_nxt >> 1);
      end
      if (fetch)      valid_q <= 1'b1;
      else if (rd_en) valid_q <= 1'b0;
    end
  end

  assign rd_flag      = fwft_mode ? valid_q : !ram_has;
  assign rd_cnt       = ram_cnt + CW'(fwft_mode && valid_q);
  assign almost_empty = (rd_cnt <= ae_offset);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (mst_rst || prt_rst)
    ram_cnt <= CW'(DEPTH)); // R4
  AST_RT_REWIND: assert property (@(posedge clk) disable iff (mst_rst || prt_rst)
    !rt_n |=> (raddr == '0 && !(fwft_mode && rd_flag))); // R9
  AST_MODE_KEEP_R: assert property (@(posedge clk) disable iff (mst_rst)
    prt_rst |=> $stable(fwft_mode)); // R8
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = ADDR_W + 1
) (
  input  logic             wr_clk,
  input  logic             rd_clk,
  input  logic             mst_rst,
  input  logic             prt_rst,
  input  logic             fwft_sel,
  input  logic [CNT_W-1:0] ae_offset,
  input  logic [CNT_W-1:0] af_offset,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] din,
  output logic             wr_flag,
  output logic             half_full,
  output logic             almost_full,
  input  logic             rd_en,
  input  logic             rt_n,
  output logic [WIDTH-1:0] dout,
  output logic             rd_flag,
  output logic             almost_empty
);
  logic              any_rst, push, fetch, fwft_mode;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [CNT_W-1:0]  wgray, rgray, wptr_rd, rptr_wr;

  assign any_rst = mst_rst || prt_rst;

  dcf_wr_ctl #(.DEPTH(DEPTH), .AW(ADDR_W), .CW(CNT_W)) u_wr (
    .clk(wr_clk), .mst_rst(mst_rst), .prt_rst(prt_rst), .fwft_sel(fwft_sel),
    .wr_en(wr_en), .af_offset(af_offset), .rptr_sync(rptr_wr),
    .push(push), .waddr(waddr), .wgray(wgray),
    .wr_flag(wr_flag), .half_full(half_full), .almost_full(almost_full));

  dcf_rd_ctl #(.DEPTH(DEPTH), .AW(ADDR_W), .CW(CNT_W)) u_rd (
    .clk(rd_clk), .mst_rst(mst_rst), .prt_rst(prt_rst), .fwft_sel(fwft_sel),
    .rd_en(rd_en), .rt_n(rt_n), .ae_offset(ae_offset), .wptr_sync(wptr_rd),
    .fetch(fetch), .raddr(raddr), .rgray(rgray),
    .rd_flag(rd_flag), .almost_empty(almost_empty), .fwft_mode(fwft_mode));

  dcf_ptr_sync #(.W(CNT_W)) u_w2r (
    .clk(rd_clk), .rst(any_rst), .gray_in(wgray), .bin_out(wptr_rd));

  dcf_ptr_sync #(.W(CNT_W)) u_r2w (
    .clk(wr_clk), .rst(any_rst), .gray_in(rgray), .bin_out(rptr_wr));

  dcf_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(ADDR_W)) u_mem (
    .wr_clk(wr_clk), .we(push), .waddr(waddr), .wdata(din),
    .rd_clk(rd_clk), .re(fetch), .raddr(raddr), .rdata(dout));

  AST_FWFT_HOLD: assert property (@(posedge rd_clk) disable iff (any_rst)
    (fwft_mode && rd_flag && !rd_en && rt_n) |=> $stable(dout)); // R3
  AST_EMPTY_HOLD: assert property (@(posedge rd_clk) disable iff (any_rst)
    (!fwft_mode && rd_flag) |=> $stable(dout)); // R4
endmodule

// File: tb/dcf_fifo_bench.sv
`timescale 1ns/1ps
module dcf_fifo_bench;
  localparam int WIDTH = 8;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam int AE    = 3;
  localparam int AF    = 4;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic mst_rst = 1'b1, prt_rst = 1'b0, fwft_sel = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, rt_n = 1'b1;
  logic [WIDTH-1:0] din = '0;
  logic [CW-1:0] ae_offset = CW'(AE), af_offset = CW'(AF);
  logic wr_flag, half_full, almost_full, rd_flag, almost_empty;
  logic [WIDTH-1:0] dout;

  int checks = 0;
  int errors = 0;
  logic [WIDTH-1:0] model_q [$];

  always #10 wr_clk = ~wr_clk;   // 50 MHz write clock
  always #14 rd_clk = ~rd_clk;   // unrelated read clock

  dcf_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dcf_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .mst_rst(mst_rst), .prt_rst(prt_rst),
    .fwft_sel(fwft_sel), .ae_offset(ae_offset), .af_offset(af_offset),
    .wr_en(wr_en), .din(din), .wr_flag(wr_flag), .half_full(half_full),
    .almost_full(almost_full), .rd_en(rd_en), .rt_n(rt_n), .dout(dout),
    .rd_flag(rd_flag), .almost_empty(almost_empty));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_hf(int k);  return k > DEPTH / 2;     endfunction
  function automatic logic exp_ae(int k);  return k <= AE;           endfunction
  function automatic logic exp_af(int k);  return k >= DEPTH - AF;   endfunction

  task automatic settle();
    repeat (8) @(negedge rd_clk);
  endtask

  task automatic do_reset(input logic master, input logic sel);
    @(negedge wr_clk);
    mst_rst = master; prt_rst = !master; fwft_sel = sel;
    repeat (4) @(negedge rd_clk);
    mst_rst = 1'b0; prt_rst = 1'b0; fwft_sel = !sel;
    settle();
  endtask

  task automatic wr_word(input logic [WIDTH-1:0] d);
    @(negedge wr_clk); wr_en = 1'b1; din = d;
    @(negedge wr_clk); wr_en = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge rd_clk); rd_en = 1'b1;
    @(negedge rd_clk); rd_en = 1'b0;
  endtask

  task automatic std_flags(input int k, input string ctx);
    chk({"R2 empty ", ctx}, 32'(rd_flag), 32'(k == 0));
    chk({"R2 full ", ctx}, 32'(wr_flag), 32'(k == DEPTH));
    chk({"R5 half_full ", ctx}, 32'(half_full), 32'(exp_hf(k)));
    chk({"R6 almost_empty ", ctx}, 32'(almost_empty), 32'(exp_ae(k)));
    chk({"R7 almost_full ", ctx}, 32'(almost_full), 32'(exp_af(k)));
  endtask

  task automatic run_random(input int n, input logic fwft);
    model_q.delete();
    fork
      begin : writer
        int sent = 0;
        while (sent < n) begin
          logic go;
          @(negedge wr_clk);
          go = ($urandom % 3) != 0;
          wr_en = go; din = WIDTH'($urandom);
          if (go && (fwft ? wr_flag : !wr_flag)) begin
            model_q.push_back(din);
            sent++;
          end
        end
        @(negedge wr_clk); wr_en = 1'b0;
      end
      begin : reader
        int got = 0;
        logic pend = 1'b0;
        logic [WIDTH-1:0] pend_val = '0;
        while (got < n || pend) begin
          logic go;
          @(negedge rd_clk);
          if (fwft) begin
            go = ($urandom % 2) != 0;
            if (rd_flag) begin
              chk("R3 random fall-through head", 32'(dout), 32'(model_q[0]));
              if (go && got < n) begin
                void'(model_q.pop_front());
                got++;
              end
            end
            rd_en = go && got < n;
          end else begin
            if (pend) begin
              chk("R2 random standard data", 32'(dout), 32'(pend_val));
              pend = 1'b0;
              got++;
            end
            go = (($urandom % 2) != 0) && (got < n);
            rd_en = go;
            if (go && !rd_flag) begin
              pend_val = model_q.pop_front();
              pend = 1'b1;
            end
          end
        end
        rd_en = 1'b0;
      end
    join
  endtask

  initial begin : watchdog
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_0042));
    // ---- fall-through mode ----
    do_reset(1'b1, 1'b1);
    chk("R1 fwft reset rd_flag", 32'(rd_flag), 32'd0);
    chk("R1 fwft reset wr_flag", 32'(wr_flag), 32'd1);
    chk("R1 fwft reset almost_empty", 32'(almost_empty), 32'd1);
    chk("R1 fwft reset half_full", 32'(half_full), 32'd0);
    wr_word(8'hA0);
    settle();
    chk("R3 head shown without read", 32'(rd_flag), 32'd1);
    chk("R3 head data", 32'(dout), 32'hA0);
    chk("R6 fwft count includes head", 32'(almost_empty), 32'd1);
    chk("R5 fwft head not in memory count", 32'(half_full), 32'd0);
    for (int i = 0; i < DEPTH; i++) wr_word(WIDTH'(i));
    settle();
    chk("R3 input ready drops at DEPTH+1", 32'(wr_flag), 32'd0);
    chk("R5 half_full at memory full", 32'(half_full), 32'd1);
    chk("R7 almost_full at memory full", 32'(almost_full), 32'd1);
    wr_word(8'hEE);
    settle();
    for (int i = -1; i < DEPTH; i++) begin
      @(negedge rd_clk);
      chk("R3 ready while draining", 32'(rd_flag), 32'd1);
      chk("R4 fwft drain order", 32'(dout), (i < 0) ? 32'hA0 : 32'(i));
      rd_pulse();
    end
    settle();
    chk("R3 ready drops after last word", 32'(rd_flag), 32'd0);
    // partial reset keeps fall-through mode even with fwft_sel low
    wr_word(8'h11);
    do_reset(1'b0, 1'b0);
    chk("R8 mode kept rd_flag", 32'(rd_flag), 32'd0);
    chk("R8 mode kept wr_flag", 32'(wr_flag), 32'd1);
    chk("R8 emptied almost_empty", 32'(almost_empty), 32'd1);
    wr_word(8'h55);
    settle();
    chk("R8 fall-through after partial reset", 32'(rd_flag), 32'd1);
    chk("R8 head after partial reset", 32'(dout), 32'h55);
    do_reset(1'b0, 1'b0);
    run_random(300, 1'b1);

    // ---- standard mode ----
    do_reset(1'b1, 1'b0);
    chk("R1 std reset rd_flag", 32'(rd_flag), 32'd1);
    chk("R1 std reset wr_flag", 32'(wr_flag), 32'd0);
    chk("R1 std reset almost_full", 32'(almost_full), 32'd0);
    std_flags(0, "reset");
    for (int k = 1; k <= DEPTH; k++) begin
      wr_word(WIDTH'(k - 1));
      settle();
      std_flags(k, "fill");
    end
    wr_word(8'hEE);
    settle();
    std_flags(DEPTH, "write at full");
    for (int k = DEPTH - 1; k >= 0; k--) begin
      rd_pulse();
      chk("R2 std order", 32'(dout), 32'(DEPTH - 1 - k));
      settle();
      std_flags(k, "drain");
    end
    rd_pulse();
    settle();
    chk("R4 read at empty keeps dout", 32'(dout), 32'(DEPTH - 1));
    chk("R4 read at empty keeps empty", 32'(rd_flag), 32'd1);

    // retransmit
    do_reset(1'b0, 1'b1);
    chk("R8 std mode kept", 32'(rd_flag), 32'd1);
    for (int i = 0; i < 5; i++) wr_word(WIDTH'(8'h40 + i));
    settle();
    for (int i = 0; i < 5; i++) begin
      rd_pulse();
      chk("R9 first pass", 32'(dout), 32'(8'h40 + i));
    end
    settle();
    chk("R9 empty before rewind", 32'(rd_flag), 32'd1);
    @(negedge rd_clk); rt_n = 1'b0;
    @(negedge rd_clk); rt_n = 1'b1;
    settle();
    chk("R9 data back after rewind", 32'(rd_flag), 32'd0);
    chk("R9 count after rewind", 32'(almost_empty), 32'(exp_ae(5)));
    for (int i = 0; i < 5; i++) begin
      rd_pulse();
      chk("R9 second pass", 32'(dout), 32'(8'h40 + i));
    end
    do_reset(1'b0, 1'b1);
    run_random(300, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule